// File: doc/BRIEF.md
# Receive Holding Queue with Break Injection

This block sits between a character-level serial receiver and the host read path. It holds up to four received bytes in arrival order. It keeps a "data waiting" flag and a "queue full" flag, and it tells the receiver whether one more character may be taken. A line-break event from the receiver is stored as a zero byte. The same event raises a sticky break-change flag, which stays set until the host clears it.

Under normal use the receiver only pushes while `can_accept` is high. The queue still stays well defined when that rule is broken. A push into a full queue overwrites the newest byte instead of being lost on the floor, so a break that arrives when the queue is full is still recorded. The receiver-reset command drives `flush`, which empties the queue in one cycle. The host takes the oldest byte by pulsing `pop`. The byte appears combinationally on `pop_data`, and it reads zero when the queue is empty.

Top module: `rx_break_fifo`

## Requirements
- R1: Bytes are returned in arrival order, oldest first. After each pop the remaining bytes keep their order, and up to DEPTH = 4 bytes are held.
- R2: A push (byte or break) while four bytes are held replaces the most recently stored byte, and the count stays at four.
- R3: Every accepted push sets `ready`. `full` is set in the cycle after the count reaches four, and `full` is never high without `ready`.
- R4: A pop clears `full`. `ready` clears when the count falls to zero.
- R5: `pop_data` shows the oldest byte when `ready` is high and 0x00 when the queue is empty. A pop on an empty queue changes no state.
- R6: A pulse on `brk_evt` stores a 0x00 byte through the same path as a received byte. When `brk_evt` and `push_valid` are high in the same cycle, the break byte is stored and the received byte is dropped.
- R7: `can_accept` is high exactly when `rx_en` is high and `full` is low. It does not gate pushes inside the block.
- R8: `flush` empties the queue and clears `ready` and `full`. It overrides a push, a break byte or a pop in the same cycle. It does not affect `brk_flag`.
- R9: When a pop and a push fall in the same cycle, the pop is served first and the push is applied afterwards. A full queue therefore stays full with the pushed byte at the tail, and an empty queue ends up holding just the pushed byte.
- R10: `brk_flag` is set by `brk_evt` and held until `brk_clr`. When `brk_evt` and `brk_clr` are high in the same cycle, the flag ends up set.
- R11: Synchronous reset empties the queue and clears `ready`, `full` and `brk_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Received byte strobe |
| push_data | input | DATA_W | Received byte |
| brk_evt | input | 1 | Line-break event strobe |
| pop | input | 1 | Host takes the oldest byte |
| pop_data | output | DATA_W | Oldest byte, or zero when empty |
| flush | input | 1 | Empty the queue (receiver reset) |
| rx_en | input | 1 | Receiver enabled |
| brk_clr | input | 1 | Clear the break-change flag |
| ready | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |
| can_accept | output | 1 | Receiver may take another character |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
Several functions can fall in the same cycle. The pairs that matter most are a host pop with a receiver push, and a break event with a host clear of the break flag. Directed steps drive pop and push together on a full queue and on an empty queue, and drive `brk_evt` together with `brk_clr`. These cases are judged against the pop-first and break-wins orderings. A randomized phase then overlaps pop, push, break, flush and clear freely, and a behavioural queue model checks every output on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic ready;
        logic full;
    } rxq_stat_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BYTE  = 2'd1,
        SRC_BREAK = 2'd2
    } rxq_src_e;

    // A break outranks a received byte in the same cycle
    function automatic rxq_src_e pick_src(input logic byte_v, input logic brk_v);
        if (brk_v)       return SRC_BREAK;
        else if (byte_v) return SRC_BYTE;
        else             return SRC_NONE;
    endfunction

endpackage

// File: rtl/rxq_track.sv
module rxq_track
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic             pop_req,
    input  logic             flush,
    output logic             pop_eff,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output rxq_stat_t        stat
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
    rxq_stat_t        stat_q, stat_d;

    always_comb begin
        pop_eff = pop_req && (cnt_q != '0) && !flush;
        cnt_mid = pop_eff ? cnt_q - 1'b1 : cnt_q;
        wr_en   = wr_req && !flush;
        wr_idx  = (cnt_mid == CNT_MAX) ? IDX_W'(DEPTH - 1) : cnt_mid[IDX_W-1:0];
        if (flush)
            cnt_d = '0;
        else if (wr_en && cnt_mid != CNT_MAX)
            cnt_d = cnt_mid + 1'b1;
        else
            cnt_d = cnt_mid;
    end

    always_comb begin
        stat_d = stat_q;
        if (flush) begin
            stat_d = '0;
        end else begin
            if (pop_eff) begin
                stat_d.full = 1'b0;
                if (cnt_mid == '0) stat_d.ready = 1'b0;
            end
            if (wr_en) begin
                stat_d.ready = 1'b1;
                if (cnt_d == CNT_MAX) stat_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            stat_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX) else $error("count above depth"); // R1

    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
        stat_q.full == (cnt_q == CNT_MAX)) else $error("full flag out of step"); // R3

    AST_READY_MATCH: assert property (@(posedge clk) disable iff (rst)
        stat_q.ready == (cnt_q != '0)) else $error("ready flag out of step"); // R4

    AST_OVERWRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && wr_req && !pop_req && !flush) |=> (cnt_q == CNT_MAX)) else $error("overwrite changed count"); // R2

    AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && wr_req && pop_req && !flush) |=> $stable(cnt_q)) else $error("pop+push changed count"); // R9

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              pop_eff,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] head
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] shifted;
        if (i < DEPTH - 1) begin : g_mid
            assign shifted = pop_eff ? slot_q[i+1] : slot_q[i];
        end else begin : g_tail
            assign shifted = slot_q[i];
        end
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i))
                slot_q[i] <= wr_data;
            else
                slot_q[i] <= shifted;
        end
    end

    assign head = slot_q[0];

endmodule

// File: rtl/rxq_brk.sv
module rxq_brk (
    input  logic clk,
    input  logic rst,
    input  logic brk_evt,
    input  logic brk_clr,
    output logic brk_flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (brk_evt)
            flag_q <= 1'b1;
        else if (brk_clr)
            flag_q <= 1'b0;
    end

    assign brk_flag = flag_q;

    AST_BREAK_WINS: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> flag_q) else $error("break lost"); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !brk_clr) |=> flag_q) else $error("flag dropped without clear"); // R10

endmodule

// File: rtl/rx_break_fifo.sv
module rx_break_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              brk_evt,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              flush,
    input  logic              rx_en,
    input  logic              brk_clr,
    output logic              ready,
    output logic              full,
    output logic              can_accept,
    output logic              brk_flag
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rxq_src_e          src;
    logic              wr_req, pop_eff, wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data, head;
    rxq_stat_t         stat;

    always_comb begin
        src     = pick_src(push_valid, brk_evt);
        wr_req  = (src != SRC_NONE);
        wr_data = (src == SRC_BREAK) ? '0 : push_data;
    end

    rxq_track #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .pop_req (pop),
        .flush   (flush),
        .pop_eff (pop_eff),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .stat    (stat)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .pop_eff (pop_eff),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .head    (head)
    );

    rxq_brk u_brk (
        .clk      (clk),
        .rst      (rst),
        .brk_evt  (brk_evt),
        .brk_clr  (brk_clr),
        .brk_flag (brk_flag)
    );

    assign ready      = stat.ready;
    assign full       = stat.full;
    assign pop_data   = stat.ready ? head : '0;
    assign can_accept = rx_en && !stat.full;

    AST_FULL_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        full |-> ready) else $error("full without ready"); // R3

    AST_PUSH_SETS_READY: assert property (@(posedge clk) disable iff (rst)
        ((push_valid || brk_evt) && !flush) |=> ready) else $error("push left queue empty"); // R3

    AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
        (full && pop && !push_valid && !brk_evt && !flush) |=> !full) else $error("pop kept full"); // R4

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (pop_data == '0)) else $error("empty read not zero"); // R5

    AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (rst)
        (!ready && pop && !push_valid && !brk_evt) |=> !ready) else $error("empty pop changed state"); // R5

    AST_BREAK_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!ready && brk_evt && !flush) |=> (ready && pop_data == '0)) else $error("break byte not zero"); // R6

    AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> !can_accept) else $error("accept while full"); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!ready && !full)) else $error("flush left data"); // R8

endmodule

// File: tb/tb_rx_break_fifo.sv
module tb_rx_break_fifo;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          push_valid, brk_evt, pop, flush, rx_en, brk_clr;
    logic [DW-1:0] push_data;
    logic [DW-1:0] pop_data;
    logic          ready, full, can_accept, brk_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [DW-1:0] mq[$];
    bit            mbrk;

    always #5 clk = ~clk;

    rx_break_fifo #(.DATA_W(DW), .DEPTH(4)) dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .brk_evt(brk_evt), .pop(pop), .pop_data(pop_data), .flush(flush),
        .rx_en(rx_en), .brk_clr(brk_clr), .ready(ready), .full(full),
        .can_accept(can_accept), .brk_flag(brk_flag)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int exp_data;
        exp_data = (mq.size() > 0) ? int'(mq[0]) : 0;
        chk(tag, "pop_data R1/R5", int'(pop_data), exp_data);
        chk(tag, "ready R3/R4", int'(ready), int'(mq.size() > 0));
        chk(tag, "full R2/R3", int'(full), int'(mq.size() == 4));
        chk(tag, "can_accept R7", int'(can_accept), int'(rx_en && mq.size() != 4));
        chk(tag, "brk_flag R10", int'(brk_flag), int'(mbrk));
    endtask

    task automatic model_update();
        logic [DW-1:0] v;
        if (brk_evt) mbrk = 1;
        else if (brk_clr) mbrk = 0;
        if (flush) begin
            mq.delete();
        end else begin
            if (pop && mq.size() > 0) void'(mq.pop_front());
            if (brk_evt || push_valid) begin
                v = brk_evt ? '0 : push_data;
                if (mq.size() == 4) mq[3] = v;
                else mq.push_back(v);
            end
        end
    endtask

    // drive at the falling edge, compare, then advance the model after the rising edge
    task automatic step(input bit pv, input logic [DW-1:0] pd, input bit bk, input bit pp,
                        input bit fl, input bit en, input bit cl, input string tag);
        @(negedge clk);
        push_valid = pv; push_data = pd; brk_evt = bk; pop = pp;
        flush = fl; rx_en = en; brk_clr = cl;
        #1;
        compare(tag);
        @(posedge clk);
        #1;
        model_update();
    endtask

    task automatic idle(input string tag);
        step(0, 8'h00, 0, 0, 0, 1, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        push_valid = 0; push_data = 0; brk_evt = 0; pop = 0;
        flush = 0; rx_en = 0; brk_clr = 0;
        rst = 1;
        mq.delete(); mbrk = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        idle("R11 reset state");

        // R3: fill to four, full set on reaching four
        step(1, 8'h11, 0, 0, 0, 1, 0, "R3 fill");
        step(1, 8'h22, 0, 0, 0, 1, 0, "R3 fill");
        step(1, 8'h33, 0, 0, 0, 1, 0, "R3 fill");
        step(1, 8'h44, 0, 0, 0, 1, 0, "R3 fill");
        idle("R3 full reached");
        // R2: overwrite newest while full
        step(1, 8'h55, 0, 0, 0, 1, 0, "R2 overwrite");
        idle("R2 after overwrite");
        // R1/R4: drain in order
        step(0, 8'h00, 0, 1, 0, 1, 0, "R4 pop clears full");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R1 order");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R1 order");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R1 order tail");
        idle("R4 ready cleared");
        // R5: pop on empty
        step(0, 8'h00, 0, 1, 0, 1, 0, "R5 empty pop");
        idle("R5 after empty pop");
        // R6: break with same-cycle byte
        step(1, 8'hA5, 1, 0, 0, 1, 0, "R6 break beats byte");
        idle("R6 zero stored");
        step(1, 8'h66, 0, 0, 0, 1, 0, "R6 byte after break");
        // R10: clear together with break, then clear alone
        step(0, 8'h00, 1, 0, 0, 1, 1, "R10 break beats clear");
        idle("R10 held");
        step(0, 8'h00, 0, 0, 0, 1, 1, "R10 clear");
        idle("R10 cleared");
        // R7: rx_en low
        step(0, 8'h00, 0, 0, 0, 0, 0, "R7 disabled");
        // R9: pop+push on full
        step(1, 8'h77, 0, 0, 0, 1, 0, "R9 refill");
        idle("R9 full");
        step(1, 8'h88, 0, 1, 0, 1, 0, "R9 pop then push full");
        idle("R9 still full");
        step(1, 8'h99, 0, 0, 0, 0, 0, "R7 full disabled");
        // R8: flush overrides push and pop, keeps brk_flag
        step(1, 8'hEE, 1, 1, 1, 1, 0, "R8 flush wins");
        idle("R8 empty after flush");
        // R9: pop+push on empty
        step(1, 8'hC3, 0, 1, 0, 1, 0, "R9 pop then push empty");
        idle("R9 one byte");
        step(0, 8'h00, 0, 1, 0, 1, 0, "R9 drain");

        // randomized overlap of all operations
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, 8'($urandom), ($urandom % 11) == 0,
                 ($urandom % 2) == 0, ($urandom % 37) == 0, ($urandom % 4) != 0,
                 ($urandom % 9) == 0, "R1 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule